// File: doc/BRIEF.md
# Compare Timer with Prescaler and Reload

A general-purpose up-counting timer driven through a small word-addressed register bus with separate read and write strobes. A programmable prescaler divides the input clock. The counter then runs from zero up to a reload limit and wraps. Each wrap is an update event: it raises a status flag and copies the buffered prescale and reload settings into their working copies. A single compare register raises a second flag when the counter steps onto its value. The counter keeps running after a match, so software can move the compare point ahead of the current count to schedule its next event.

The counter, reload and compare registers are `CNT_W` bits wide (16 or 32). The prescale register is 16 bits. Bits written above these widths are dropped, so software can find the width by writing all ones to the reload register and reading it back. The interrupt line is a level. It stays high while any enabled flag is set.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, interrupt-enable, status, counter, prescale and compare registers read 0. The reload register reads all ones of `CNT_W` bits, and `irq` is low.
- R2: The register word indices are control 0x0, interrupt enable 0x3, status 0x4, event 0x5, counter 0x9, prescale 0xA, reload 0xB and compare 0xD. Counter, reload and compare keep only the low `CNT_W` bits of a write, and prescale keeps the low 16 bits. Unused upper bits read 0, and reads return 0 while `rd_en` is low.
- R3: While control bit 0 (run) is set, the counter advances once every (working prescale + 1) clocks. While run is clear, the counter holds.
- R4: Writing 1 to event bit 0 clears the counter and the prescale divider. It loads the prescale and reload registers into their working copies and sets status bit 0 (update flag).
- R5: A counter step taken while the counter equals the effective reload value returns the counter to 0. This wrap sets the update flag and reloads the working copies, unless control bit 1 (update inhibit) is set. In that case the counter still wraps to 0, but no flag is set and nothing is reloaded.
- R6: When control bit 3 (single shot) is set, a wrap clears the run bit.
- R7: When control bit 7 (reload buffering) is set, the effective reload value is the working copy, which changes only at an update event. When bit 7 is clear, a written reload value takes effect at once. Reads of the reload register always return the last written value.
- R8: A counter step that lands on the compare value sets status bit 1 (compare flag). The counter continues counting past the match.
- R9: A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A hardware set in the same cycle wins over the clear.
- R10: `irq` is high whenever (update flag AND interrupt-enable bit 0) OR (compare flag AND interrupt-enable bit 1). It stays high until software clears the flag or its enable bit.
- R11: A write to the counter register loads the count directly. A software update in the same cycle takes priority over that write, and the write takes priority over a counter step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| rd_en | input | 1 | Read strobe, enables rdata |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that a single write arrives per cycle, that `addr` and `wdata` are valid whenever `wr_en` is high, and that reset is applied before any traffic. They exclude the cycles in which software writes the counter, control or status register, because those writes legitimately override hardware behaviour. The stimulus changes the bus on falling edges only, with one operation per cycle. It stops the counter before any read whose value depends on the count. It also counts the exact number of enabled rising edges between the start and stop writes, so every expected count follows from the prescale and reload rules alone.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_IE   = 4'h3;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_EVT  = 4'h5;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'h9;
  localparam logic [ADDR_W-1:0] A_PSC  = 4'hA;
  localparam logic [ADDR_W-1:0] A_ARR  = 4'hB;
  localparam logic [ADDR_W-1:0] A_CMP  = 4'hD;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_INH  = 1;
  localparam int CTRL_ONE  = 3;
  localparam int CTRL_BUF  = 7;
  localparam int IE_UPD    = 0;
  localparam int IE_CMP    = 1;
  localparam int ST_UPD    = 0;
  localparam int ST_CMP    = 1;
  localparam int EVT_UPD   = 0;

  // Sticky flag update: hardware set wins, a written 0 clears, a written 1 keeps.
  function automatic logic flag_next(logic cur, logic hw_set, logic sw_wr, logic wbit);
    return hw_set | (cur & ~(sw_wr & ~wbit));
  endfunction

  function automatic logic irq_of(logic upd_f, logic cmp_f, logic upd_ie, logic cmp_ie);
    return (upd_f & upd_ie) | (cmp_f & cmp_ie);
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             load,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             tick
);
  logic [PSC_W-1:0] act_q;
  logic [PSC_W-1:0] div_q;

  function automatic logic [PSC_W-1:0] div_next(logic [PSC_W-1:0] d, logic t);
    return t ? '0 : d + PSC_W'(1);
  endfunction

  assign tick = run && (div_q == act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      div_q <= '0;
    end else begin
      if (load) act_q <= psc_pre;
      if (restart)  div_q <= '0;
      else if (run) div_q <= div_next(div_q, tick);
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ug,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic             buf_en,
  input  logic             inhibit,
  input  logic [CNT_W-1:0] arr_wr,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             upd_evt,
  output logic             cmp_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] arr_eff;
  logic [CNT_W-1:0] cnt_nx;
  logic             at_top;
  logic             advance;

  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] c, logic top);
    return top ? '0 : c + CNT_W'(1);
  endfunction

  assign arr_eff = buf_en ? shadow_q : arr_wr;
  assign at_top  = (cnt_q == arr_eff);
  assign advance = tick & ~ug & ~wr_cnt;
  assign cnt_nx  = step(cnt_q, at_top);
  assign wrap    = advance & at_top;
  assign upd_evt = ug | (wrap & ~inhibit);
  assign cmp_hit = advance & (cnt_nx == cmp_val);
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '1;
    end else begin
      if (ug)           cnt_q <= '0;
      else if (wr_cnt)  cnt_q <= cnt_wval;
      else if (advance) cnt_q <= cnt_nx;
      if (upd_evt) shadow_q <= arr_wr;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic en_q, inh_q, one_q, buf_q;
  logic upd_ie_q, cmp_ie_q;
  logic uif_q, cif_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] arr_q, cmp_q, cnt_q;

  logic wr_ctrl, wr_ie, wr_stat, wr_cnt, wr_psc, wr_arr, wr_cmp, ug;
  logic tick, wrap, upd_evt, cmp_hit;
  logic unused_wdata;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_ie   = wr_en && (addr == A_IE);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_cnt  = wr_en && (addr == A_CNT);
  assign wr_psc  = wr_en && (addr == A_PSC);
  assign wr_arr  = wr_en && (addr == A_ARR);
  assign wr_cmp  = wr_en && (addr == A_CMP);
  assign ug      = wr_en && (addr == A_EVT) && wdata[EVT_UPD];
  assign unused_wdata = ^wdata;

  tick_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(ug), .load(upd_evt),
    .psc_pre(psc_q), .tick(tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ug(ug), .wr_cnt(wr_cnt),
    .cnt_wval(wdata[CNT_W-1:0]), .buf_en(buf_q), .inhibit(inh_q),
    .arr_wr(arr_q), .cmp_val(cmp_q), .cnt(cnt_q), .wrap(wrap),
    .upd_evt(upd_evt), .cmp_hit(cmp_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; inh_q <= 1'b0; one_q <= 1'b0; buf_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= wdata[CTRL_RUN];
      inh_q <= wdata[CTRL_INH];
      one_q <= wdata[CTRL_ONE];
      buf_q <= wdata[CTRL_BUF];
    end else if (wrap && one_q) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_ie_q <= 1'b0;
      cmp_ie_q <= 1'b0;
      uif_q    <= 1'b0;
      cif_q    <= 1'b0;
      psc_q    <= '0;
      arr_q    <= '1;
      cmp_q    <= '0;
    end else begin
      if (wr_ie) begin
        upd_ie_q <= wdata[IE_UPD];
        cmp_ie_q <= wdata[IE_CMP];
      end
      uif_q <= flag_next(uif_q, upd_evt, wr_stat, wdata[ST_UPD]);
      cif_q <= flag_next(cif_q, cmp_hit, wr_stat, wdata[ST_CMP]);
      if (wr_psc) psc_q <= wdata[PSC_W-1:0];
      if (wr_arr) arr_q <= wdata[CNT_W-1:0];
      if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
    end
  end

  assign irq = irq_of(uif_q, cif_q, upd_ie_q, cmp_ie_q);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL: begin
          rdata[CTRL_RUN] = en_q;
          rdata[CTRL_INH] = inh_q;
          rdata[CTRL_ONE] = one_q;
          rdata[CTRL_BUF] = buf_q;
        end
        A_IE: begin
          rdata[IE_UPD] = upd_ie_q;
          rdata[IE_CMP] = cmp_ie_q;
        end
        A_STAT: begin
          rdata[ST_UPD] = uif_q;
          rdata[ST_CMP] = cif_q;
        end
        A_CNT:   rdata = DATA_W'(cnt_q);
        A_PSC:   rdata = DATA_W'(psc_q);
        A_ARR:   rdata = DATA_W'(arr_q);
        A_CMP:   rdata = DATA_W'(cmp_q);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              en,
  input logic              udis,
  input logic              opm,
  input logic              uif,
  input logic              cif,
  input logic [CNT_W-1:0]  cnt,
  input logic              tick,
  input logic              wrap,
  input logic              cmp_hit
);
  logic c_ug, c_wr_cnt, c_wr_ctrl, c_wr_stat, c_wr_ie;
  logic unused_chk;
  assign c_ug      = wr_en && (addr == A_EVT) && wdata[EVT_UPD];
  assign c_wr_cnt  = wr_en && (addr == A_CNT);
  assign c_wr_ctrl = wr_en && (addr == A_CTRL);
  assign c_wr_stat = wr_en && (addr == A_STAT);
  assign c_wr_ie   = wr_en && (addr == A_IE);
  assign unused_chk = ^wdata;

  AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    c_ug |=> (cnt == '0) && uif); // R4
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !c_ug && !c_wr_cnt && !wrap) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !c_ug && !c_wr_cnt) |=> $stable(cnt)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R5
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && udis && !c_ug && !c_wr_stat) |=> uif == $past(uif)); // R5
  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && opm && !c_wr_ctrl) |=> !en); // R6
  AST_CMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> cif); // R8
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr_stat && wdata[ST_UPD] && uif) |=> uif); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !c_wr_stat && !c_wr_ie) |=> irq); // R10
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .en(en_q), .udis(inh_q), .opm(one_q), .uif(uif_q), .cif(cif_q),
  .cnt(cnt_q), .tick(tick), .wrap(wrap), .cmp_hit(cmp_hit)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  logic        w32 = 1'b0, r32 = 1'b0;
  logic [3:0]  a32 = '0;
  logic [31:0] d32 = '0;
  logic [31:0] q32;
  logic        irq32;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  tick_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));
  tick_timer #(.CNT_W(32)) dut32 (.clk(clk), .rst_n(rst_n), .wr_en(w32), .rd_en(r32),
                  .addr(a32), .wdata(d32), .rdata(q32), .irq(irq32));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Driver: issues the read and queues the value the requirements predict.
  task automatic bus_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    @(negedge clk); addr = a; rd_en = 1'b1; exp_q.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // Monitor: pops one expected item per read cycle.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rd_en) begin
        if (exp_q.size() == 0) check(rdata, 32'hDEAD_BEEF, "queue");
        else begin
          exp_t it;
          it = exp_q.pop_front();
          check(rdata, it.val, it.tag);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(4'h0, 32'h0, "R1 ctrl");
    bus_rd(4'h3, 32'h0, "R1 ie");
    bus_rd(4'h4, 32'h0, "R1 status");
    bus_rd(4'h9, 32'h0, "R1 count");
    bus_rd(4'hA, 32'h0, "R1 prescale");
    bus_rd(4'hB, 32'h0000FFFF, "R1 reload");
    bus_rd(4'hD, 32'h0, "R1 compare");
    check({31'd0, irq}, 32'h0, "R1 irq");

    // R2 truncation and map, R11 direct count load
    bus_wr(4'hB, 32'hFFFF_FFFF);
    bus_rd(4'hB, 32'h0000FFFF, "R2 reload 16b");
    bus_wr(4'hA, 32'h0001_2345);
    bus_rd(4'hA, 32'h0000_2345, "R2 prescale 16b");
    bus_wr(4'h9, 32'h0001_ABCD);
    bus_rd(4'h9, 32'h0000_ABCD, "R11 count load");
    bus_wr(4'hD, 32'hFFFF_00FF);
    bus_rd(4'hD, 32'h0000_00FF, "R2 compare 16b");
    @(negedge clk); a32 = 4'hB; d32 = 32'hFFFF_FFFF; w32 = 1'b1;
    @(negedge clk); w32 = 1'b0; a32 = 4'hB; r32 = 1'b1; #1;
    check(q32, 32'hFFFF_FFFF, "R2 reload 32b");
    @(negedge clk); r32 = 1'b0;

    // R4 software update, R3 prescaled stepping
    bus_wr(4'hA, 32'd2);
    bus_wr(4'h5, 32'd1);
    bus_rd(4'h9, 32'd0, "R4 count cleared");
    bus_rd(4'h4, 32'd1, "R4 update flag");
    bus_wr(4'h4, 32'd0);
    bus_rd(4'h4, 32'd0, "R9 clear by zero");
    bus_wr(4'h0, 32'h1);
    repeat (9) @(negedge clk);
    bus_wr(4'h0, 32'h0);               // 11 enabled edges, divide by 3
    bus_rd(4'h9, 32'd3, "R3 prescaled count");

    // R5 wrap, R7 immediate reload
    bus_wr(4'hA, 32'd0);
    bus_wr(4'h5, 32'd1);
    bus_wr(4'hB, 32'd4);
    bus_wr(4'h4, 32'd0);
    bus_wr(4'h0, 32'h1);
    repeat (5) @(negedge clk);
    bus_wr(4'h0, 32'h0);               // 7 edges: 0..4,0,1,2
    bus_rd(4'h9, 32'd2, "R7 immediate reload wrap");
    bus_rd(4'h4, 32'd1, "R5 wrap sets flag");

    // R5 update inhibit
    bus_wr(4'h4, 32'd0);
    bus_wr(4'h0, 32'h3);
    repeat (5) @(negedge clk);
    bus_wr(4'h0, 32'h2);               // 7 edges from 2
    bus_rd(4'h9, 32'd4, "R5 inhibited wrap count");
    bus_rd(4'h4, 32'd0, "R5 inhibited no flag");

    // R6 single shot
    bus_wr(4'h0, 32'h9);
    repeat (4) @(negedge clk);
    bus_rd(4'h0, 32'h8, "R6 run cleared");
    bus_rd(4'h9, 32'd0, "R6 stopped at zero");
    bus_rd(4'h4, 32'd1, "R6 flag");

    // R7 buffered reload
    bus_wr(4'h4, 32'd0);
    bus_wr(4'h0, 32'h80);
    bus_wr(4'hB, 32'd2);
    bus_rd(4'hB, 32'd2, "R7 reload readback");
    bus_wr(4'h0, 32'h81);
    repeat (1) @(negedge clk);
    bus_wr(4'h0, 32'h80);              // 3 edges: old limit 4 still used
    bus_rd(4'h9, 32'd3, "R7 old limit active");
    bus_rd(4'h4, 32'd0, "R7 no wrap yet");
    bus_wr(4'h0, 32'h81);
    repeat (1) @(negedge clk);
    bus_wr(4'h0, 32'h80);              // 4,0(load 2),1
    bus_wr(4'h0, 32'h81);
    bus_wr(4'h0, 32'h80);              // 2,0
    bus_rd(4'h9, 32'd0, "R7 new limit after update");
    bus_rd(4'h4, 32'd1, "R7 update flag");

    // R8 compare and R10 interrupt
    bus_wr(4'h0, 32'h0);
    bus_wr(4'h4, 32'd0);
    bus_wr(4'hD, 32'd2);
    bus_wr(4'h3, 32'h2);
    check({31'd0, irq}, 32'd0, "R10 irq idle");
    bus_wr(4'h0, 32'h1);
    repeat (2) @(negedge clk);
    check({31'd0, irq}, 32'd1, "R8 R10 compare irq");
    bus_wr(4'h0, 32'h0);               // 2 more edges: wrap to 0, then 1
    bus_rd(4'h9, 32'd1, "R8 counter continues");
    bus_rd(4'h4, 32'd3, "R8 both flags");

    // R9 write-one keeps, R10 level
    bus_wr(4'h4, 32'd1);
    bus_rd(4'h4, 32'd1, "R9 keep update clear compare");
    check({31'd0, irq}, 32'd0, "R10 irq drops with flag");
    bus_wr(4'h3, 32'h1);
    check({31'd0, irq}, 32'd1, "R10 update irq");
    repeat (3) @(negedge clk);
    check({31'd0, irq}, 32'd1, "R10 irq held");
    bus_wr(4'h4, 32'd0);
    check({31'd0, irq}, 32'd0, "R10 irq cleared");
    bus_rd(4'h4, 32'd0, "R9 all clear");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule